// File: doc/BRIEF.md
# Tag-Ordered Variable-Delay Release Queue

This block sits after a set of parallel lookup pipelines. Each pipeline exit drives one lane of the block. Every item on a lane carries three fields: a next-hop pointer, a hold count and a small arrival tag. The block keeps each item for exactly the number of cycles named by its hold count, then releases it. Upstream logic chooses these counts so that items leave in flow order.

Each lane is a shift line with a single entrance and an exit at every stage. It has as many stages as the input queue capacity `STAGES`. A stored item moves one stage per cycle and its count falls by one at each stage. The item leaves at the stage where the count reaches zero. An item that arrives with a count of zero passes straight to the output in its arrival cycle.

A combinational merge gathers the releases of all lanes in each cycle. It sorts them by arrival tag and packs them toward output lane 0. All sizes are set in the configuration package `dlyq_pkg`.

Top module: `dlyq_order_top`

## Requirements
- R1: An item accepted with a hold count of 0 appears on the outputs in the same cycle it is presented.
- R2: An item accepted in cycle t with hold count d, where 1 <= d <= STAGES, appears on the outputs in cycle t+d, and in no earlier cycle.
- R3: A hold count larger than STAGES is treated as STAGES. The `dly_err` bit of that lane is high in the arrival cycle only, and only when `in_vld` is also high.
- R4: Every accepted item is output exactly once, with its next-hop pointer and tag unchanged.
- R5: Upstream logic must never give two items of one lane the same release cycle. Under that rule, each lane releases at most one item per cycle, even when a later item leaves before an earlier one.
- R6: Lanes are independent: an item's release time depends only on its own arrival cycle and hold count.
- R7: Items released in the same cycle are output in ascending tag order. When two tags are equal, the item from the lower-numbered input lane comes first. Tags take the values 1 to LANES.
- R8: The N items released in a cycle occupy output lanes 0 to N-1. Output lanes with `out_vld` low drive zero on their next-hop and tag fields.
- R9: Reset is synchronous and active high. It discards every stored item, so nothing accepted before reset is ever output.
- R10: When `in_vld` is low for a lane, the next-hop, hold count and tag fields of that lane have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | LANES | Item valid, one bit per lane |
| in_nh | input | LANES*NH_W | Next-hop pointer, lane w at bits [w*NH_W +: NH_W] |
| in_dly | input | LANES*DLY_W | Hold count in cycles, lane w at bits [w*DLY_W +: DLY_W] |
| in_tag | input | LANES*TAG_W | Arrival tag (1 to LANES), lane w at bits [w*TAG_W +: TAG_W] |
| out_vld | output | LANES | Output valid, packed from lane 0 upward |
| out_nh | output | LANES*NH_W | Sorted next-hop pointers |
| out_tag | output | LANES*TAG_W | Sorted tags |
| dly_err | output | LANES | Hold count above STAGES on that lane in this cycle |

## Verification
Directed patterns each target one behaviour:
- a zero count on its own checks the bypass path;
- counts of 1 to STAGES check the release cycle exactly;
- oversized counts check clamping and the error bit.

Three further patterns separate the release cycle from the arrival order:
- several lanes released together with scrambled and repeated tags, which checks both the sort order and the lane tie-break;
- sparse releases on upper lanes, which checks compaction;
- one lane fed with shrinking counts, so later items leave before earlier ones.

Invalid lanes carrying live-looking data check that such data is ignored. A reset with items still in flight checks that the stored items are dropped. Long random runs mix all of these, using random tags and counts up to STAGES+3, and are compared against a cycle-indexed release schedule computed in the bench.

// File: rtl/dlyq_pkg.sv
package dlyq_pkg;

    localparam int LANES  = 4;
    localparam int STAGES = 8;
    localparam int NH_W   = 8;
    localparam int DLY_W  = $clog2(STAGES + 1);
    localparam int TAG_W  = $clog2(LANES + 1);
    localparam int RANK_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int HIT_W  = STAGES + 1;

    typedef struct packed {
        logic             vld;
        logic [NH_W-1:0]  nh;
        logic [TAG_W-1:0] tag;
    } rel_t;

    typedef struct packed {
        logic             vld;
        logic [NH_W-1:0]  nh;
        logic [TAG_W-1:0] tag;
        logic [DLY_W-1:0] cnt;
    } slot_t;

    function automatic logic [DLY_W-1:0] clamp_dly(input logic [DLY_W-1:0] d);
        return (d > DLY_W'(STAGES)) ? DLY_W'(STAGES) : d;
    endfunction

    // a goes before b: smaller tag first, lower lane on equal tags
    function automatic logic goes_before(input logic [TAG_W-1:0] tag_a, input int lane_a,
                                         input logic [TAG_W-1:0] tag_b, input int lane_b);
        return (tag_a < tag_b) || ((tag_a == tag_b) && (lane_a < lane_b));
    endfunction

endpackage

// File: rtl/dlyq_lane.sv
module dlyq_lane
    import dlyq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_vld,
    input  logic [NH_W-1:0]      in_nh,
    input  logic [DLY_W-1:0]     in_dly,
    input  logic [TAG_W-1:0]     in_tag,
    output rel_t                 rel,
    output logic                 dly_err,
    output logic [HIT_W-1:0]     hits
);

    slot_t            st   [STAGES];
    slot_t            st_n [STAGES];
    logic [DLY_W-1:0] dly_c;

    // exits: bit 0 is the entrance bypass, bit k+1 is stage k
    always_comb begin
        dly_c   = clamp_dly(in_dly);
        dly_err = in_vld && (in_dly > DLY_W'(STAGES));
        hits    = '0;
        hits[0] = in_vld && (dly_c == '0);
        for (int k = 0; k < STAGES; k++) begin
            hits[k+1] = st[k].vld && (st[k].cnt == '0);
        end
    end

    always_comb begin
        rel = '0;
        if (hits[0]) begin
            rel = '{vld: 1'b1, nh: in_nh, tag: in_tag};
        end
        for (int k = 0; k < STAGES; k++) begin
            if (hits[k+1]) begin
                rel = '{vld: 1'b1, nh: st[k].nh, tag: st[k].tag};
            end
        end
    end

    always_comb begin
        st_n[0] = '0;
        if (in_vld && (dly_c != '0)) begin
            st_n[0] = '{vld: 1'b1, nh: in_nh, tag: in_tag, cnt: dly_c - DLY_W'(1)};
        end
        for (int k = 1; k < STAGES; k++) begin
            st_n[k] = '0;
            if (st[k-1].vld && (st[k-1].cnt != '0)) begin
                st_n[k] = '{vld: 1'b1, nh: st[k-1].nh, tag: st[k-1].tag,
                            cnt: st[k-1].cnt - DLY_W'(1)};
            end
        end
    end

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                st[k] <= '0;
            end else begin
                st[k] <= st_n[k];
            end
        end
    end

endmodule

// File: rtl/dlyq_merge.sv
module dlyq_merge
    import dlyq_pkg::*;
(
    input  rel_t rel_in  [LANES],
    output rel_t rel_out [LANES]
);

    logic [RANK_W-1:0] rank [LANES];

    // output slot of each release = number of valid releases ordered ahead of it
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            rank[i] = '0;
            for (int j = 0; j < LANES; j++) begin
                if ((j != i) && rel_in[j].vld &&
                    goes_before(rel_in[j].tag, j, rel_in[i].tag, i)) begin
                    rank[i] = rank[i] + RANK_W'(1);
                end
            end
        end
    end

    always_comb begin
        for (int r = 0; r < LANES; r++) begin
            rel_out[r] = '0;
            for (int i = 0; i < LANES; i++) begin
                if (rel_in[i].vld && (rank[i] == RANK_W'(r))) begin
                    rel_out[r] = rel_in[i];
                end
            end
        end
    end

endmodule

// File: rtl/dlyq_order_top.sv
module dlyq_order_top
    import dlyq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [LANES-1:0]         in_vld,
    input  logic [LANES*NH_W-1:0]    in_nh,
    input  logic [LANES*DLY_W-1:0]   in_dly,
    input  logic [LANES*TAG_W-1:0]   in_tag,
    output logic [LANES-1:0]         out_vld,
    output logic [LANES*NH_W-1:0]    out_nh,
    output logic [LANES*TAG_W-1:0]   out_tag,
    output logic [LANES-1:0]         dly_err
);

    rel_t                     lane_rel [LANES];
    rel_t                     mrg_rel  [LANES];
    logic [LANES*HIT_W-1:0]   hits_flat;

    for (genvar w = 0; w < LANES; w++) begin : g_lane
        dlyq_lane u_lane (
            .clk     (clk),
            .rst     (rst),
            .in_vld  (in_vld[w]),
            .in_nh   (in_nh[w*NH_W +: NH_W]),
            .in_dly  (in_dly[w*DLY_W +: DLY_W]),
            .in_tag  (in_tag[w*TAG_W +: TAG_W]),
            .rel     (lane_rel[w]),
            .dly_err (dly_err[w]),
            .hits    (hits_flat[w*HIT_W +: HIT_W])
        );
    end

    dlyq_merge u_merge (
        .rel_in  (lane_rel),
        .rel_out (mrg_rel)
    );

    for (genvar r = 0; r < LANES; r++) begin : g_out
        assign out_vld[r]                 = mrg_rel[r].vld;
        assign out_nh[r*NH_W +: NH_W]     = mrg_rel[r].nh;
        assign out_tag[r*TAG_W +: TAG_W]  = mrg_rel[r].tag;
    end

endmodule

// File: rtl/dlyq_chk.sv
module dlyq_chk
    import dlyq_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic [LANES-1:0]       in_vld,
    input logic [LANES*DLY_W-1:0] in_dly,
    input logic [LANES-1:0]       dly_err,
    input logic [LANES-1:0]       out_vld,
    input logic [LANES*TAG_W-1:0] out_tag,
    input logic [LANES*HIT_W-1:0] hits_flat
);

    int exit_cnt;

    always_comb begin
        exit_cnt = 0;
        for (int w = 0; w < LANES; w++) begin
            if (|hits_flat[w*HIT_W +: HIT_W]) exit_cnt++;
        end
    end

    a_r4_count_matches: assert property (@(posedge clk) disable iff (rst)
        $countones(out_vld) == exit_cnt);

    for (genvar w = 0; w < LANES; w++) begin : g_lane_chk
        a_r5_single_exit: assert property (@(posedge clk) disable iff (rst)
            $countones(hits_flat[w*HIT_W +: HIT_W]) <= 1);

        a_r3_err_cause: assert property (@(posedge clk) disable iff (rst)
            dly_err[w] |-> (in_vld[w] && (in_dly[w*DLY_W +: DLY_W] > DLY_W'(STAGES))));

        a_r1_bypass: assert property (@(posedge clk) disable iff (rst)
            (in_vld[w] && (in_dly[w*DLY_W +: DLY_W] == '0)) |-> out_vld[0]);

        a_r9_flushed: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (hits_flat[w*HIT_W+1 +: STAGES] == '0));
    end

    for (genvar r = 0; r + 1 < LANES; r++) begin : g_out_chk
        a_r8_packed: assert property (@(posedge clk) disable iff (rst)
            !out_vld[r] |-> !out_vld[r+1]);

        a_r7_ascending: assert property (@(posedge clk) disable iff (rst)
            out_vld[r+1] |-> (out_tag[r*TAG_W +: TAG_W] <= out_tag[(r+1)*TAG_W +: TAG_W]));
    end

endmodule

bind dlyq_order_top dlyq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (in_vld),
    .in_dly    (in_dly),
    .dly_err   (dly_err),
    .out_vld   (out_vld),
    .out_tag   (out_tag),
    .hits_flat (hits_flat)
);

// File: tb/tb_dlyq_order_top.sv
module tb_dlyq_order_top;
    import dlyq_pkg::*;

    localparam int W    = LANES;
    localparam int S    = STAGES;
    localparam int RING = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [W-1:0]       in_vld = '0;
    logic [W*NH_W-1:0]  in_nh  = '0;
    logic [W*DLY_W-1:0] in_dly = '0;
    logic [W*TAG_W-1:0] in_tag = '0;
    logic [W-1:0]       out_vld;
    logic [W*NH_W-1:0]  out_nh;
    logic [W*TAG_W-1:0] out_tag;
    logic [W-1:0]       dly_err;

    dlyq_order_top dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_nh(in_nh), .in_dly(in_dly),
        .in_tag(in_tag), .out_vld(out_vld), .out_nh(out_nh), .out_tag(out_tag),
        .dly_err(dly_err)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    bit               rv   [W][RING];
    logic [NH_W-1:0]  rnh  [W][RING];
    logic [TAG_W-1:0] rtag [W][RING];

    bit               dv   [W];
    logic [NH_W-1:0]  dnh  [W];
    int               ddly [W];
    logic [TAG_W-1:0] dtag [W];

    function automatic int eff_dly(input int d);
        return (d > S) ? S : d;
    endfunction

    task automatic clear_ring;
        for (int w = 0; w < W; w++)
            for (int i = 0; i < RING; i++) rv[w][i] = 1'b0;
    endtask

    task automatic clear_drive;
        for (int w = 0; w < W; w++) begin
            dv[w] = 1'b0; dnh[w] = '0; ddly[w] = 0; dtag[w] = '0;
        end
    endtask

    function automatic bit slot_free(input int lane, input int d);
        return !rv[lane][(cyc + eff_dly(d)) % RING];
    endfunction

    task automatic put(input int lane, input int d, input int nh, input int tag);
        dv[lane] = 1'b1; ddly[lane] = d; dnh[lane] = NH_W'(nh); dtag[lane] = TAG_W'(tag);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual=%h expected=%h", req, what, cyc, act, exp);
        end
    endtask

    task automatic run(input string req);
        logic [W-1:0]       ev;
        logic [W*NH_W-1:0]  enh;
        logic [W*TAG_W-1:0] etag;
        logic [W-1:0]       eerr;
        int n;
        int slot;
        @(negedge clk);
        for (int w = 0; w < W; w++) begin
            in_vld[w]                 = dv[w];
            in_nh[w*NH_W +: NH_W]     = dnh[w];
            in_dly[w*DLY_W +: DLY_W]  = DLY_W'(ddly[w]);
            in_tag[w*TAG_W +: TAG_W]  = dtag[w];
            eerr[w]                   = dv[w] && (ddly[w] > S);
            if (!rst && dv[w]) begin
                slot = (cyc + eff_dly(ddly[w])) % RING;
                rv[w][slot]   = 1'b1;
                rnh[w][slot]  = dnh[w];
                rtag[w][slot] = dtag[w];
            end
        end
        #1;
        ev = '0; enh = '0; etag = '0; n = 0;
        slot = cyc % RING;
        for (int t = 1; t <= W; t++) begin
            for (int w = 0; w < W; w++) begin
                if (!rst && rv[w][slot] && (rtag[w][slot] == TAG_W'(t))) begin
                    ev[n] = 1'b1;
                    enh[n*NH_W +: NH_W]    = rnh[w][slot];
                    etag[n*TAG_W +: TAG_W] = rtag[w][slot];
                    n++;
                end
            end
        end
        check(out_vld == ev, req, "out_vld", 64'(out_vld), 64'(ev));
        check(out_nh == enh, req, "out_nh", 64'(out_nh), 64'(enh));
        check(out_tag == etag, req, "out_tag", 64'(out_tag), 64'(etag));
        if (!rst) check(dly_err == eerr, "R3", "dly_err", 64'(dly_err), 64'(eerr));
        for (int w = 0; w < W; w++) rv[w][slot] = 1'b0;
        cyc++;
        clear_drive();
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) run(req);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL R4 watchdog: actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        clear_ring();
        clear_drive();
        rst = 1'b1;
        idle(3, "R9");
        rst = 1'b0;
        idle(2, "R9");

        // R1: zero hold bypasses the stages
        put(0, 0, 'h11, 2);
        run("R1");

        // R2: exact release cycle
        put(1, 3, 'h22, 1);
        run("R2");
        idle(4, "R2");
        put(3, S, 'h2F, 4);
        run("R2");
        idle(S + 1, "R2");

        // R3: oversized hold clamps to S
        put(2, S + 5, 'h33, 3);
        run("R3");
        idle(S + 1, "R3");

        // R7: scrambled tags with a tie between lanes 0 and 3
        put(0, 2, 'hC0, 2); put(1, 2, 'hC1, 1); put(3, 2, 'hC3, 2); put(2, 2, 'hC2, 4);
        run("R7");
        idle(3, "R7");

        // R8: releases only on upper lanes pack to lane 0
        put(1, 1, 'hD1, 4); put(3, 1, 'hD3, 2);
        run("R8");
        idle(2, "R8");

        // R10: live-looking data without valid
        dnh[0] = 'hEE; ddly[0] = 0; dtag[0] = 1;
        dnh[2] = 'hEF; ddly[2] = S + 2; dtag[2] = 2;
        run("R10");
        idle(S + 1, "R10");

        // R5: one lane, later items overtake earlier ones
        put(2, 4, 'h51, 1); run("R5");
        put(2, 2, 'h52, 1); run("R5");
        put(2, 0, 'h53, 1); run("R5");
        idle(4, "R5");

        // R6: every lane a different hold
        put(0, 1, 'h61, 1); put(1, 2, 'h62, 2); put(2, 3, 'h63, 3); put(3, 4, 'h64, 4);
        run("R6");
        idle(5, "R6");

        // R9: reset with items in flight
        put(0, S, 'h91, 1); put(1, 5, 'h92, 2);
        run("R9");
        put(2, 6, 'h93, 3);
        run("R9");
        rst = 1'b1;
        clear_ring();
        idle(2, "R9");
        rst = 1'b0;
        idle(S + 2, "R9");

        // R4: random traffic respecting the one-release-per-cycle rule
        for (int c = 0; c < 400; c++) begin
            for (int w = 0; w < W; w++) begin
                int d;
                d = $urandom_range(0, S + 3);
                dnh[w]  = NH_W'($urandom);
                dtag[w] = TAG_W'($urandom_range(1, W));
                ddly[w] = d;
                dv[w]   = ($urandom_range(0, 9) < 7) && slot_free(w, d);
            end
            run("R4");
        end
        idle(S + 2, "R4");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule